// File: doc/BRIEF.md
# Per-Source Routed Interrupt Controller

This block gathers 26 interrupt sources and drives two processor request lines, a normal request (IRQ) and a fast request (FIQ). Sources 0 to 5 come from external pins that are asynchronous to the bus clock. Sources 6 to 25 come from on-chip peripherals that already run on the bus clock.

Software sets up the block through a small word-addressed register port. For each source it chooses:
- level or edge sensitivity;
- whether the source is enabled (unmasked);
- which of the two request lines the source drives.

Software can read the raw and the enabled pending status. It clears latched edges by writing ones. It can also read, for each request line, the index of the lowest-numbered enabled pending source.

Top module: `intc_top`

## Requirements
- R1: After reset the MODE, ENABLE and ROUTE registers read zero. This means every source is masked, level-sensitive and routed to IRQ. `irq_o` and `fiq_o` are low, and both index fields read 31.
- R2: The registers sit at word addresses 0 MODE (bit 1 = edge), 1 ENABLE (bit 1 = unmasked), 2 ROUTE (bit 1 = FIQ), 3 RAW (read pending; write ones to clear), 4 MASKED (read pending AND enable) and 5 INDEX (read only). Bit i of each register is source i. Bits 31:26 read zero, and writes to addresses 4 and 5 are ignored.
- R3: External sources 0 to 5 pass through a two-flop synchroniser. A level change on `ext_i` appears in RAW after the second rising clock edge and not after the first.
- R4: A level-sensitive source's pending bit follows its input and is never latched.
- R5: An edge-sensitive source sets its pending bit on a rising input edge. The bit stays set after the input falls until a one is written to its RAW bit. Writing zero leaves it set.
- R6: A clear write has no effect on a level-sensitive source whose input is high.
- R7: `irq_o` is the registered OR of the enabled pending sources with ROUTE bit 0. `fiq_o` is the same for ROUTE bit 1. Each output changes one clock edge after the pending state does.
- R8: INDEX bits 4:0 hold the lowest-numbered enabled pending source routed to IRQ, and bits 20:16 hold the same for FIQ. Each field reads 31 when no such source exists.
- R9: Switching a source from edge to level mode discards its latched edge. Its pending bit then follows the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| ext_i | input | 6 | Asynchronous external sources 0 to 5 |
| int_i | input | 20 | Synchronous internal sources 6 to 25 |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench probes the synchroniser latency cycle by cycle. A design missing a flop shows the external level one edge early, and a design with an extra flop shows it late.

Edge sources get a one-cycle pulse followed by zero-valued and one-valued clear writes. A controller that follows the input instead of latching would lose the pulse. One that decodes clears loosely would drop the bit on the zero write.

Mixed routing with several pending sources checks that each line reports only its own lowest index, and that a masked lower source is skipped. A reversed priority scan or a shared index would show up here.

Clearing a high level source, and leaving edge mode with a latched bit, catch designs that keep stale pending state.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned N_EXT = 6;
  localparam int unsigned N_INT = 20;
  localparam int unsigned N_SRC = N_EXT + N_INT;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 3;
  localparam int unsigned IW    = $clog2(N_SRC + 1);
  localparam int unsigned FIQ_IDX_LSB = 16;

  typedef enum logic [AW-1:0] {
    REG_MODE   = 3'd0,
    REG_ENABLE = 3'd1,
    REG_ROUTE  = 3'd2,
    REG_RAW    = 3'd3,
    REG_MASKED = 3'd4,
    REG_INDEX  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = d_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/intc_src_cell.sv
module intc_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, prev_d;
  logic latch_q, latch_d;
  logic rise;

  always_comb begin
    rise    = in_i & ~prev_q;
    prev_d  = in_i;
    if (edge_mode_i) begin
      latch_d = (latch_q & ~clr_i) | rise;
    end else begin
      latch_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  assign pend_o = edge_mode_i ? latch_q : in_i;
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int unsigned N  = 26,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [N_INT-1:0] int_i,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int unsigned PADW = DW - N_SRC;

  logic             rst_sync_n;
  logic [N_EXT-1:0] ext_s;
  logic [N_SRC-1:0] src_in;
  logic [N_SRC-1:0] mode_q, mode_d;
  logic [N_SRC-1:0] en_q, en_d;
  logic [N_SRC-1:0] route_q, route_d;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] irq_vec, fiq_vec;
  logic [IW-1:0]    irq_idx, fiq_idx;
  logic             irq_q, irq_d, fiq_q, fiq_d;
  logic             wr_en;

  intc_sync #(.W(1)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  intc_sync #(.W(N_EXT)) u_ext_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (ext_i),
    .q_o   (ext_s)
  );

  assign src_in = {int_i, ext_s};
  assign wr_en  = sel_i & wr_i;

  always_comb begin
    mode_d  = mode_q;
    en_d    = en_q;
    route_d = route_q;
    clr     = '0;
    if (wr_en) begin
      unique case (addr_i)
        REG_MODE:   mode_d  = wdata_i[N_SRC-1:0];
        REG_ENABLE: en_d    = wdata_i[N_SRC-1:0];
        REG_ROUTE:  route_d = wdata_i[N_SRC-1:0];
        REG_RAW:    clr     = wdata_i[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      route_q <= route_d;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    intc_src_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .in_i       (src_in[g]),
      .edge_mode_i(mode_q[g]),
      .clr_i      (clr[g]),
      .pend_o     (pend[g])
    );
  end

  assign live    = pend & en_q;
  assign irq_vec = live & ~route_q;
  assign fiq_vec = live & route_q;

  intc_lowest #(.N(N_SRC), .IW(IW)) u_irq_lowest (
    .vec_i(irq_vec),
    .idx_o(irq_idx)
  );

  intc_lowest #(.N(N_SRC), .IW(IW)) u_fiq_lowest (
    .vec_i(fiq_vec),
    .idx_o(fiq_idx)
  );

  always_comb begin
    irq_d = |irq_vec;
    fiq_d = |fiq_vec;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_MODE:   rdata_o = {{PADW{1'b0}}, mode_q};
      REG_ENABLE: rdata_o = {{PADW{1'b0}}, en_q};
      REG_ROUTE:  rdata_o = {{PADW{1'b0}}, route_q};
      REG_RAW:    rdata_o = {{PADW{1'b0}}, pend};
      REG_MASKED: rdata_o = {{PADW{1'b0}}, live};
      REG_INDEX: begin
        rdata_o[IW-1:0]                     = irq_idx;
        rdata_o[FIQ_IDX_LSB+IW-1:FIQ_IDX_LSB] = fiq_idx;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_check.sv
module intc_check
  import intc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [N_SRC-1:0] mode_q,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] clr_bits;
  logic [N_SRC-1:0] kept;
  assign clr_bits = (sel_i && wr_i && addr_i == REG_RAW) ? wdata_i[N_SRC-1:0] : '0;
  assign kept     = pend & mode_q & ~clr_bits;

  // R5: a latched edge survives until cleared while the source stays in edge mode
  a_r5_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend & $past(kept) & mode_q) == ($past(kept) & mode_q)));

  // R7: no request line rises from a fully masked state
  a_r7_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> (!irq_o && !fiq_o));

  // R8: each index field is a legal source number or all ones
  a_r8_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == REG_INDEX) |->
      ((rdata_o[IW-1:0] < N_SRC || rdata_o[IW-1:0] == '1) &&
       (rdata_o[FIQ_IDX_LSB+IW-1:FIQ_IDX_LSB] < N_SRC ||
        rdata_o[FIQ_IDX_LSB+IW-1:FIQ_IDX_LSB] == '1)));

  // R8: with every source masked both index fields report none
  a_r8_none_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0 && sel_i && !wr_i && addr_i == REG_INDEX) |->
      (rdata_o[IW-1:0] == '1 && rdata_o[FIQ_IDX_LSB+IW-1:FIQ_IDX_LSB] == '1));

  // R2: upper read bits are always zero outside the index register
  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != REG_INDEX) |-> (rdata_o[DW-1:N_SRC] == '0));
endmodule

bind intc_top intc_check u_intc_check (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .sel_i  (sel_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .fiq_o  (fiq_o),
  .mode_q (mode_q),
  .en_q   (en_q),
  .pend   (pend)
);

// File: tb/intc_top_bench.sv
module intc_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sel_i, wr_i;
  logic [2:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [5:0]  ext_i;
  logic [19:0] int_i;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  intc_top u_intc_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ext_i(ext_i), .int_i(int_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic [25:0] en;
    logic [25:0] route;
    logic [25:0] src;
    logic        eirq;
    logic        efiq;
    logic [4:0]  iidx;
    logic [4:0]  fidx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{26'h0,        26'h0,        26'h3FFFFFF, 1'b0, 1'b0, 5'd31, 5'd31},
    '{26'h8,        26'h0,        26'h8,       1'b1, 1'b0, 5'd3,  5'd31},
    '{26'h3FFFFFF,  26'h400,      26'h100400,  1'b1, 1'b1, 5'd20, 5'd10},
    '{26'h3FFFFFF,  26'h3FFFFFF,  26'h2000080, 1'b0, 1'b1, 5'd31, 5'd7},
    '{26'h3FFFFFE,  26'h0,        26'h5,       1'b1, 1'b0, 5'd2,  5'd31},
    '{26'h3FFFFFF,  26'h0,        26'h0,       1'b0, 1'b0, 5'd31, 5'd31}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic drive_src(input logic [25:0] s);
    ext_i = s[5:0];
    int_i = s[25:6];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    rst_ni = 1'b0; sel_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    ext_i = '0; int_i = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1: reset state
    bus_rd(3'd0, rd); check("R1 mode", rd, 32'h0);
    bus_rd(3'd1, rd); check("R1 enable", rd, 32'h0);
    bus_rd(3'd2, rd); check("R1 route", rd, 32'h0);
    bus_rd(3'd5, rd); check("R1 index", rd, 32'h001F001F);
    check("R1 irq/fiq", {30'h0, irq_o, fiq_o}, 32'h0);

    // R7 R8 R4: table walk, all sources level-sensitive
    for (int v = 0; v < NV; v++) begin
      bus_wr(3'd0, 32'h0);
      bus_wr(3'd1, {6'h0, VECS[v].en});
      bus_wr(3'd2, {6'h0, VECS[v].route});
      drive_src(VECS[v].src);
      repeat (4) @(negedge clk_i);
      check($sformatf("R7 vec%0d irq", v), {31'h0, irq_o}, {31'h0, VECS[v].eirq});
      check($sformatf("R7 vec%0d fiq", v), {31'h0, fiq_o}, {31'h0, VECS[v].efiq});
      bus_rd(3'd5, rd);
      check($sformatf("R8 vec%0d index", v), rd,
            {11'h0, VECS[v].fidx, 11'h0, VECS[v].iidx});
      bus_rd(3'd3, rd);
      check($sformatf("R4 vec%0d raw", v), rd, {6'h0, VECS[v].src});
      bus_rd(3'd4, rd);
      check($sformatf("R2 vec%0d masked", v), rd, {6'h0, VECS[v].src & VECS[v].en});
    end
    drive_src('0);
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd2, 32'h0);
    repeat (3) @(negedge clk_i);

    // R2: unused bits and read-only registers
    bus_wr(3'd0, 32'hFFFFFFFF);
    bus_rd(3'd0, rd); check("R2 mode width", rd, 32'h03FFFFFF);
    bus_wr(3'd0, 32'h0);
    bus_wr(3'd5, 32'h12345678);
    bus_rd(3'd5, rd); check("R2 index read-only", rd, 32'h001F001F);
    bus_wr(3'd4, 32'hFFFFFFFF);
    bus_rd(3'd4, rd); check("R2 masked read-only", rd, 32'h0);

    // R3: external synchroniser latency
    ext_i[0] = 1'b1;
    @(negedge clk_i);
    bus_rd(3'd3, rd); check("R3 after one edge", rd, 32'h0);
    @(negedge clk_i);
    bus_rd(3'd3, rd); check("R3 after two edges", rd, 32'h1);
    ext_i[0] = 1'b0;
    repeat (3) @(negedge clk_i);

    // R7: one-edge output latency on an internal level source (source 6)
    bus_wr(3'd1, 32'h40);
    int_i[0] = 1'b1;
    #1;
    check("R7 irq before edge", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    check("R7 irq after edge", {31'h0, irq_o}, 32'h1);

    // R6: clearing a high level source has no effect
    bus_wr(3'd3, 32'h40);
    bus_rd(3'd3, rd); check("R6 level clear ignored", rd, 32'h40);
    int_i[0] = 1'b0;
    bus_wr(3'd1, 32'h0);

    // R5: edge latch on source 8
    bus_wr(3'd0, 32'h100);
    bus_wr(3'd1, 32'h100);
    int_i[2] = 1'b1;
    @(negedge clk_i);
    int_i[2] = 1'b0;
    repeat (2) @(negedge clk_i);
    bus_rd(3'd3, rd); check("R5 latched", rd, 32'h100);
    check("R5 irq", {31'h0, irq_o}, 32'h1);
    bus_wr(3'd3, 32'h0);
    bus_rd(3'd3, rd); check("R5 zero clear keeps", rd, 32'h100);
    bus_wr(3'd3, 32'h100);
    bus_rd(3'd3, rd); check("R5 one clear drops", rd, 32'h0);
    @(negedge clk_i);
    check("R5 irq drops", {31'h0, irq_o}, 32'h0);

    // R9: leaving edge mode discards the latch
    int_i[2] = 1'b1;
    @(negedge clk_i);
    int_i[2] = 1'b0;
    @(negedge clk_i);
    bus_rd(3'd3, rd); check("R9 latched first", rd, 32'h100);
    bus_wr(3'd0, 32'h0);
    bus_rd(3'd3, rd); check("R9 level follows", rd, 32'h0);
    bus_wr(3'd0, 32'h100);
    bus_rd(3'd3, rd); check("R9 no stale latch", rd, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule